// File: doc/BRIEF.md
# Periodic Wakeup Interrupt Timer

This block is a free-running wakeup timer controlled through one byte-wide status/control register. It counts ticks from one of two sources. The first is a 1 kHz tick from the low-frequency oscillator, which never stops. The second is a fast tick that only counts while the chip is in run mode. A parameterised prescaler divides the fast tick down to the same 1 kHz rate. When the selected period has elapsed, the block sets a sticky flag, reloads its counter and starts the next period.

The interrupt request is raised while the flag and the enable bit are both set. Software clears the flag by writing one to a separate acknowledge bit. Writes to the flag bit itself have no effect. A dedicated input, pulsed when the chip leaves its deepest stop state, also clears the flag.

Top module: `wkt_top`

## Requirements
- R1: Read layout on `bus_rdata` while `bus_sel` is high:
  - bit 7 is the flag.
  - bit 5 is the clock select (0 = slow tick, 1 = fast tick).
  - bit 4 is the interrupt enable.
  - bits 2:0 are the period code.
  - bits 6 and 3 always read zero.
- R2: After reset every register bit is zero, so `bus_rdata` reads 0x00 and `irq` is low.
- R3: With a period code n from 1 to 7, the flag sets on the edge that counts the 2^n-th tick after a restart: 2, 4, 8, 16, 32, 64 or 128 ms of 1 kHz ticks.
- R4: Writing a one or a zero to bit 7 never changes the flag.
- R5: Period code 000 stops the timer, so the flag never sets however many ticks arrive.
- R6: A write with bit 6 = 1 clears the flag. A write with bit 6 = 0 leaves the flag unchanged.
- R7: `irq` is high exactly when the flag and the enable bit are both one.
- R8: The counter reloads after each expiry, so the flag sets again after another full period. A write that changes the period code or the clock select restarts the count from zero.
- R9: With clock select 1:
  - the flag sets after 2^n × HF_DIV fast ticks;
  - slow ticks are ignored;
  - fast ticks that arrive while `run_mode` is low are not counted.
- R10: If an expiry and an acknowledge write fall in the same cycle, the flag stays set.
- R11: A pulse on `deep_exit` clears the flag, and it takes priority over an expiry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lf_tick | input | 1 | One-cycle pulse at the 1 kHz slow rate |
| hf_tick | input | 1 | One-cycle pulse from the fast clock domain |
| run_mode | input | 1 | High while the chip is in run mode |
| deep_exit | input | 1 | Pulse on exit from the deepest stop state |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe, used together with `bus_sel` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register read data; zero when not selected |
| irq | output | 1 | Interrupt request |

## Verification
A counter or prescaler that holds a wrong value cannot be read back. It shows only as a flag that rises one or more ticks too early or too late, and that is seen on `bus_rdata` bit 7 on the edge that counts the wrong tick. For this reason the bench counts ticks exactly up to one short of each period, and then exactly to the period. A wrong flag or enable value shows at once on `irq` and on the read data, one edge after the write, tick or exit pulse that caused it. A missed restart shows only at the end of the following period.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  localparam int SEL_W   = 3;
  localparam int MAX_LOG = (1 << SEL_W) - 1;
  localparam int CNT_W   = MAX_LOG + 1;

  localparam int FLAG_BIT = 7;
  localparam int ACK_BIT  = 6;
  localparam int CLK_BIT  = 5;
  localparam int EN_BIT   = 4;

  // Number of 1 kHz ticks in one period for a non-zero code.
  function automatic logic [CNT_W-1:0] period_ticks(input logic [SEL_W-1:0] code);
    logic [CNT_W-1:0] one;
    one = {{(CNT_W-1){1'b0}}, 1'b1};
    return one << code;
  endfunction

  function automatic logic [7:0] pack_status(input logic flag, input logic csel,
                                             input logic en, input logic [SEL_W-1:0] per);
    logic [7:0] v;
    v = '0;
    v[FLAG_BIT] = flag;
    v[CLK_BIT]  = csel;
    v[EN_BIT]   = en;
    v[SEL_W-1:0] = per;
    return v;
  endfunction
endpackage

// File: rtl/wkt_regs.sv
module wkt_regs
  import wkt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wdata,
  input  logic             expire,
  input  logic             deep_exit,
  output logic             flag,
  output logic             clk_sel,
  output logic             int_en,
  output logic [SEL_W-1:0] per_sel,
  output logic             restart,
  output logic             ack_hit
);
  logic wr_unused_bits;
  assign wr_unused_bits = ^{wdata[FLAG_BIT], wdata[3]};

  assign ack_hit = wr_en && wdata[ACK_BIT];
  assign restart = wr_en && ((wdata[SEL_W-1:0] != per_sel) || (wdata[CLK_BIT] != clk_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sel <= 1'b0;
      int_en  <= 1'b0;
      per_sel <= '0;
    end else if (wr_en) begin
      clk_sel <= wdata[CLK_BIT];
      int_en  <= wdata[EN_BIT];
      per_sel <= wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag <= 1'b0;
    else if (deep_exit)  flag <= 1'b0;
    else if (expire)     flag <= 1'b1;
    else if (ack_hit)    flag <= 1'b0;
  end

  // R3
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(expire));
  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !expire) |=> !flag);
  // R10
  expire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !deep_exit) |=> flag);
  // R11
  deep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deep_exit |=> !flag);
endmodule

// File: rtl/wkt_tick_src.sv
module wkt_tick_src #(
  parameter int HF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_sel,
  input  logic lf_tick,
  input  logic hf_tick,
  input  logic run_mode,
  input  logic restart,
  output logic tick
);
  logic hf_pulse;

  generate
    if (HF_DIV <= 1) begin : g_direct
      assign hf_pulse = hf_tick && run_mode;
    end else begin : g_prescale
      localparam int PW = $clog2(HF_DIV);
      localparam logic [PW-1:0] PLAST = PW'(HF_DIV - 1);
      logic [PW-1:0] pre_cnt;
      logic          hf_step;

      assign hf_step  = clk_sel && run_mode && hf_tick && !restart;
      assign hf_pulse = hf_step && (pre_cnt == PLAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pre_cnt <= '0;
        else if (restart) pre_cnt <= '0;
        else if (hf_step) pre_cnt <= (pre_cnt == PLAST) ? '0 : pre_cnt + 1'b1;
      end

      // R9
      prescale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_mode && !restart) |=> $stable(pre_cnt));
    end
  endgenerate

  assign tick = clk_sel ? hf_pulse : lf_tick;

  // R9
  fast_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel && !run_mode) |-> !tick);
endmodule

// File: rtl/wkt_period_cnt.sv
module wkt_period_cnt
  import wkt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [SEL_W-1:0] per_sel,
  input  logic             restart,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             active;

  assign limit  = period_ticks(per_sel);
  assign active = (per_sel != '0) && !restart;
  assign expire = active && tick && (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!active) cnt <= '0;
    else if (tick)    cnt <= expire ? '0 : cnt + 1'b1;
  end

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_sel != '0) |-> (cnt < limit));
  // R8
  count_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
  // R5
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_sel == '0) |=> (cnt == '0));
endmodule

// File: rtl/wkt_top.sv
module wkt_top
  import wkt_pkg::*;
#(
  parameter int HF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lf_tick,
  input  logic       hf_tick,
  input  logic       run_mode,
  input  logic       deep_exit,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  logic             wr_en;
  logic             flag, clk_sel, int_en, restart, ack_hit, tick, expire;
  logic [SEL_W-1:0] per_sel;

  assign wr_en = bus_sel && bus_wr;

  wkt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(bus_wdata),
    .expire(expire), .deep_exit(deep_exit), .flag(flag), .clk_sel(clk_sel),
    .int_en(int_en), .per_sel(per_sel), .restart(restart), .ack_hit(ack_hit)
  );

  wkt_tick_src #(.HF_DIV(HF_DIV)) u_src (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .lf_tick(lf_tick),
    .hf_tick(hf_tick), .run_mode(run_mode), .restart(restart), .tick(tick)
  );

  wkt_period_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .per_sel(per_sel),
    .restart(restart), .expire(expire)
  );

  assign bus_rdata = bus_sel ? pack_status(flag, clk_sel, int_en, per_sel) : 8'h00;
  assign irq       = flag && int_en;

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !expire && !deep_exit) |=> !irq);
  // R4
  flag_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ack_hit && !expire && !deep_exit) |=> $stable(flag));
endmodule

// File: tb/tb_wkt_top.sv
module tb_wkt_top;
  localparam int HF_DIV = 4;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       lf_tick = 0, hf_tick = 0, run_mode = 1, deep_exit = 0;
  logic       bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       irq;
  int         errors = 0, checks = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  wkt_top #(.HF_DIV(HF_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .lf_tick(lf_tick), .hf_tick(hf_tick),
    .run_mode(run_mode), .deep_exit(deep_exit), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_wdata = d;
    step();
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(output logic [7:0] v);
    bus_sel = 1; #1; v = bus_rdata; bus_sel = 0;
  endtask

  task automatic flag_is(input string req, input logic exp);
    logic [7:0] v;
    rd(v);
    chk(req, {7'b0, v[7]}, {7'b0, exp});
  endtask

  task automatic lf(input int n);
    for (int i = 0; i < n; i++) begin
      lf_tick = 1; step(); lf_tick = 0; step();
    end
  endtask

  task automatic hf(input int n);
    for (int i = 0; i < n; i++) begin
      hf_tick = 1; step(); hf_tick = 0; step();
    end
  endtask

  task automatic t_reset_layout();
    logic [7:0] v;
    rd(v); chk("R2 reset read", v, 8'h00);
    chk("R2 reset irq", {7'b0, irq}, 8'h00);
    wr(8'hFF); rd(v); chk("R1 layout, R4 flag write ignored", v, 8'h37);
    wr(8'h7F); rd(v); chk("R1 ack/bit3 read zero", v, 8'h37);
    wr(8'h00); rd(v); chk("R1 cleared", v, 8'h00);
  endtask

  task automatic t_basic_2ms();
    logic [7:0] v;
    wr(8'h01);
    lf(1); flag_is("R3 2ms one tick short", 0);
    lf(1); flag_is("R3 2ms period", 1);
    chk("R7 irq off while disabled", {7'b0, irq}, 8'h00);
    wr(8'h01); flag_is("R4 write zero to flag", 1);
    wr(8'h81); flag_is("R6 ack zero keeps flag", 1);
    wr(8'h41); rd(v); chk("R6 ack clears flag", v, 8'h01);
    wr(8'h81); flag_is("R4 write one to flag", 0);
  endtask

  task automatic t_enable_reload();
    wr(8'h13);
    lf(7); flag_is("R3 8ms short", 0);
    chk("R7 irq low", {7'b0, irq}, 8'h00);
    lf(1); flag_is("R3 8ms period", 1);
    chk("R7 irq high", {7'b0, irq}, 8'h01);
    wr(8'h53); chk("R7 irq drops on ack", {7'b0, irq}, 8'h00);
    lf(7); flag_is("R8 reload short", 0);
    lf(1); flag_is("R8 reload period", 1);
    wr(8'h53);
  endtask

  task automatic t_off();
    wr(8'h10);
    lf(300); flag_is("R5 code 000 never sets", 0);
    chk("R5 irq stays low", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_restart();
    wr(8'h02); lf(3);
    wr(8'h03);
    lf(7); flag_is("R8 restart on code change", 0);
    lf(1); flag_is("R8 full period after restart", 1);
    wr(8'h53);
  endtask

  task automatic t_fast();
    run_mode = 1;
    wr(8'h21);
    lf(3); flag_is("R9 slow ticks ignored", 0);
    hf(2*HF_DIV - 1); flag_is("R9 fast one short", 0);
    hf(1); flag_is("R9 fast period", 1);
    wr(8'h61);
    run_mode = 0; hf(20); flag_is("R9 paused outside run mode", 0);
    run_mode = 1;
    hf(2*HF_DIV - 1); flag_is("R9 resumed short", 0);
    hf(1); flag_is("R9 resumed period", 1);
    wr(8'h61);
  endtask

  task automatic t_collide();
    wr(8'h01);
    lf(1);
    bus_sel = 1; bus_wr = 1; bus_wdata = 8'h41; lf_tick = 1;
    step();
    bus_sel = 0; bus_wr = 0; bus_wdata = 0; lf_tick = 0;
    flag_is("R10 expiry beats ack", 1);
    wr(8'h41); flag_is("R6 later ack clears", 0);
  endtask

  task automatic t_deep();
    lf(2); flag_is("R11 flag before exit", 1);
    deep_exit = 1; step(); deep_exit = 0;
    flag_is("R11 exit clears", 0);
    lf(1);
    lf_tick = 1; deep_exit = 1; step(); lf_tick = 0; deep_exit = 0;
    flag_is("R11 exit beats expiry", 0);
  endtask

  task automatic t_long();
    logic [7:0] v;
    wr(8'h07);
    lf(127); flag_is("R3 128ms short", 0);
    lf(1); rd(v); chk("R3 128ms period", v, 8'h87);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    t_reset_layout();
    t_basic_2ms();
    t_enable_reload();
    t_off();
    t_restart();
    t_fast();
    t_collide();
    t_deep();
    t_long();
    finish_run();
  end
endmodule